// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Split Bit-Rate Divisor

This block is an asynchronous serial port for a 32-bit register bus. Software pushes characters into a transmit queue and pops received characters from a receive queue, both through one data register. A 12-bit bit-rate divisor is written in two parts, eight low bits and four high bits. A separate line-settings register holds the word length, the parity, the stop bits, break forcing and the queue enable. Both directions run on a 16x bit clock derived from the single input clock.

After each data read, the receive status register holds the framing, parity and overrun condition of the character just taken. Two level interrupt lines tell the host when received data is waiting and when the transmit queue has room. The usual sequence is to disable the port, write both divisor parts and the line settings, then enable the port again.

Top module: `uart_splitdiv`

## Requirements
- R1: One bit period lasts 16*(D+1) clock cycles, where D = {divisor-high[3:0], divisor-low[7:0]}. The divisor-low register is at byte offset 0x10 and the divisor-high register is at 0x0C.
- R2: A transmitted frame is one low start bit, then the data bits LSB first, then an optional parity bit, then one or two high stop bits. The data bit count comes from line-settings bits 6:5 (00=5, 01=6, 10=7, 11=8). Bit 1 enables parity, bit 2 set selects even parity and clear selects odd, and bit 3 selects two stop bits. The line-settings register is at offset 0x08.
- R3: While line-settings bit 0 is set, txd is held low whatever the queue contents.
- R4: Received characters are returned in arrival order from the data register (offset 0x00), right-aligned, with the unused upper bits zero. Writing that register queues a character for sending.
- R5: The receive status register (offset 0x04) describes the character most recently read from the data register: bit 0 framing error (first stop bit sampled low), bit 1 parity error, bit 2 overrun.
- R6: A character that completes while the receive queue is full is discarded. The overrun bit is then reported with the next character read.
- R7: The receiver samples each bit at tick 8 of 16 and abandons a start bit that is high again at that point.
- R8: Each queue holds 16 characters when line-settings bit 4 is set, and 1 character when it is clear. A write to a full transmit queue is ignored.
- R9: Control register bit 0 (offset 0x14) enables the port and reads back as written. While it is clear, nothing is sent and nothing is received.
- R10: The flag register (offset 0x18) shows bit 3 = a character is shifting out, bit 4 = receive queue empty, bit 5 = transmit queue full.
- R11: irq_rx is high while the receive queue holds data. irq_tx is high while the port is enabled and the transmit queue is not full.
- R12: After reset txd is high, both interrupts are low, the control register reads 0 and the flag register reads 0x10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all logic and the bit-rate divider |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Byte address within the 32-byte register window |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; a read of the data register pops the receive queue |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid combinationally while bus_rd and bus_addr are held |
| rxd | input | 1 | Serial receive line, idle high |
| txd | output | 1 | Serial transmit line, idle high |
| irq_rx | output | 1 | Received data waiting |
| irq_tx | output | 1 | Transmit queue has room and port enabled |

## Verification
The transmitter is looped back to the receiver with 8-bit frames, 7-bit odd-parity frames and 5-bit even-parity frames with two stop bits. The line is also decoded bit by bit at mid-bit, which separates wrong bit order, wrong parity sense and wrong stop count from a merely matching round trip. The start bit is timed with a divisor that has a nonzero high part, which catches a dropped or misplaced upper divisor field. Hand-driven frames with a bad parity bit, a low stop bit, a short glitch and seventeen back-to-back characters show that each error bit appears only on the character it belongs to, and that the queues stop at their limit in both depth modes.

// File: rtl/uart_sd_pkg.sv
`timescale 1ns/1ps
// Shared types and register decode for the split-divisor serial port.
// Assumes a word-aligned register window addressed by byte address bits 4:2.
package uart_sd_pkg;
    localparam int CHAR_W = 8;
    localparam int DIVL_W = 8;
    localparam int DIVM_W = 4;
    localparam int DIV_W  = DIVL_W + DIVM_W;

    // word index of each register (byte offset / 4)
    localparam logic [2:0] RG_DATA = 3'd0;
    localparam logic [2:0] RG_RXST = 3'd1;
    localparam logic [2:0] RG_LINE = 3'd2;
    localparam logic [2:0] RG_DIVM = 3'd3;
    localparam logic [2:0] RG_DIVL = 3'd4;
    localparam logic [2:0] RG_CTRL = 3'd5;
    localparam logic [2:0] RG_FLAG = 3'd6;

    // line settings, packed so bit positions match the register layout
    typedef struct packed {
        logic [1:0] wlen;      // 6:5
        logic       q_en;      // 4
        logic       two_stop;  // 3
        logic       par_even;  // 2
        logic       par_on;    // 1
        logic       brk;       // 0
    } line_cfg_t;

    // one receive queue entry
    typedef struct packed {
        logic              par_err;
        logic              frm_err;
        logic [CHAR_W-1:0] data;
    } rx_word_t;

    typedef enum logic [2:0] {
        SH_IDLE, SH_START, SH_DATA, SH_PAR, SH_STOP
    } shift_st_e;

    // number of data bits for a word-length code
    function automatic logic [3:0] word_bits(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction
endpackage

// File: rtl/uart_tick.sv
`timescale 1ns/1ps
// 16x bit-clock enable generator: pulses once every (div+1) cycles while run
// is high and restarts from zero whenever run drops, so a frame always begins
// on a whole tick boundary.
module uart_tick #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    // count clocks up to the divisor, restarting on each tick
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/uart_fifo.sv
`timescale 1ns/1ps
// Circular queue with a run-time depth limit: one_deep caps it at one entry.
// Pushes when full and pops when empty are dropped. The head is combinational.
module uart_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         one_deep,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = one_deep ? !empty : (cnt == CAP);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    // storage write
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    // pointers and fill count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end

    // R8
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/uart_tx.sv
`timescale 1ns/1ps
// Transmit shifter: takes a character from the queue when idle and enabled,
// then sends start, LSB-first data, optional parity and one or two stop bits,
// each 16 ticks long. Line settings are assumed stable while a frame is sent.
module uart_tx
    import uart_sd_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  line_cfg_t         cfg,
    input  logic [DIV_W-1:0]  div,
    input  logic              q_empty,
    input  logic [CHAR_W-1:0] q_data,
    output logic              pop,
    output logic              txd_q,
    output logic              busy
);
    shift_st_e         st;
    logic [3:0]        tcnt;
    logic [3:0]        bidx;
    logic [CHAR_W-1:0] sh;
    logic              par_acc;
    logic              tick;
    logic [3:0]        nbits;

    assign nbits = word_bits(cfg.wlen);
    assign busy  = (st != SH_IDLE);
    assign pop   = en && (st == SH_IDLE) && !q_empty;

    uart_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(busy), .div(div), .tick(tick)
    );

    // frame sequencer: advances one bit every 16 ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= SH_IDLE;
            txd_q   <= 1'b1;
            tcnt    <= '0;
            bidx    <= '0;
            sh      <= '0;
            par_acc <= 1'b0;
        end else if (pop) begin
            st      <= SH_START;
            txd_q   <= 1'b0;
            sh      <= q_data;
            tcnt    <= '0;
            bidx    <= '0;
            par_acc <= 1'b0;
        end else if (tick) begin
            tcnt <= tcnt + 1'b1;
            if (tcnt == 4'd15) begin
                unique case (st)
                    SH_START: begin
                        st      <= SH_DATA;
                        txd_q   <= sh[0];
                        par_acc <= sh[0];
                        sh      <= sh >> 1;
                        bidx    <= 4'd1;
                    end
                    SH_DATA: begin
                        if (bidx == nbits) begin
                            bidx <= '0;
                            if (cfg.par_on) begin
                                st    <= SH_PAR;
                                txd_q <= cfg.par_even ? par_acc : ~par_acc;
                            end else begin
                                st    <= SH_STOP;
                                txd_q <= 1'b1;
                            end
                        end else begin
                            txd_q   <= sh[0];
                            par_acc <= par_acc ^ sh[0];
                            sh      <= sh >> 1;
                            bidx    <= bidx + 1'b1;
                        end
                    end
                    SH_PAR: begin
                        st    <= SH_STOP;
                        txd_q <= 1'b1;
                    end
                    SH_STOP: begin
                        if (cfg.two_stop && bidx == '0) bidx <= 4'd1;
                        else                            st   <= SH_IDLE;
                    end
                    default: st <= SH_IDLE;
                endcase
            end
        end
    end

    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SH_START) |-> !txd_q);

    // R9
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && st == SH_IDLE) |=> (st == SH_IDLE));
endmodule

// File: rtl/uart_rx.sv
`timescale 1ns/1ps
// Receive shifter: synchronises rxd, detects a falling edge, confirms the
// start bit at tick 8, then samples every 16 ticks. It reports a completed
// character as a one-cycle push with its parity and framing flags.
module uart_rx
    import uart_sd_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  line_cfg_t        cfg,
    input  logic [DIV_W-1:0] div,
    input  logic             rxd,
    output logic             push,
    output rx_word_t         word
);
    shift_st_e         st;
    logic              rxd_m, rxd_s;
    logic [3:0]        tcnt;
    logic [3:0]        bidx;
    logic [CHAR_W-1:0] sh;
    logic              par_acc, par_bad;
    logic              tick;
    logic [3:0]        nbits;

    assign nbits = word_bits(cfg.wlen);

    uart_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(st != SH_IDLE), .div(div), .tick(tick)
    );

    // two-stage synchroniser for the asynchronous line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxd_m <= 1'b1;
            rxd_s <= 1'b1;
        end else begin
            rxd_m <= rxd;
            rxd_s <= rxd_m;
        end
    end

    // frame sequencer: mid-bit sampling and character completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= SH_IDLE;
            tcnt    <= '0;
            bidx    <= '0;
            sh      <= '0;
            par_acc <= 1'b0;
            par_bad <= 1'b0;
            push    <= 1'b0;
            word    <= '0;
        end else begin
            push <= 1'b0;
            if (!en) begin
                st <= SH_IDLE;
            end else if (st == SH_IDLE) begin
                if (!rxd_s) begin
                    st   <= SH_START;
                    tcnt <= '0;
                end
            end else if (tick) begin
                tcnt <= tcnt + 1'b1;
                unique case (st)
                    SH_START: if (tcnt == 4'd7) begin
                        tcnt    <= '0;
                        bidx    <= '0;
                        par_acc <= 1'b0;
                        par_bad <= 1'b0;
                        st      <= rxd_s ? SH_IDLE : SH_DATA;
                    end
                    SH_DATA: if (tcnt == 4'd15) begin
                        sh      <= {rxd_s, sh[CHAR_W-1:1]};
                        par_acc <= par_acc ^ rxd_s;
                        bidx    <= bidx + 1'b1;
                        if (bidx + 4'd1 == nbits)
                            st <= cfg.par_on ? SH_PAR : SH_STOP;
                    end
                    SH_PAR: if (tcnt == 4'd15) begin
                        par_bad <= (rxd_s != (cfg.par_even ? par_acc : ~par_acc));
                        st      <= SH_STOP;
                    end
                    SH_STOP: if (tcnt == 4'd15) begin
                        push         <= 1'b1;
                        word.data    <= sh >> (4'd8 - nbits);
                        word.frm_err <= !rxd_s;
                        word.par_err <= par_bad;
                        st           <= SH_IDLE;
                    end
                    default: st <= SH_IDLE;
                endcase
            end
        end
    end

    // R7
    false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st == SH_START && tick && tcnt == 4'd7 && rxd_s) |=> (st == SH_IDLE));
endmodule

// File: rtl/uart_splitdiv.sv
`timescale 1ns/1ps
// Top of the serial port: register decode, the two queues and the two
// shifters. Bus strobes are single-cycle. Read data is combinational, and a
// data-register read pops the receive queue at the clock edge that ends it.
module uart_splitdiv
    import uart_sd_pkg::*;
#(
    parameter int Q_DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        rxd,
    output logic        txd,
    output logic        irq_rx,
    output logic        irq_tx
);
    localparam int RXW_W = $bits(rx_word_t);

    line_cfg_t         line;
    logic [DIVL_W-1:0] div_lo;
    logic [DIVM_W-1:0] div_hi;
    logic              port_en;
    logic [2:0]        rxstat;
    logic              ovr_pend;
    logic [DIV_W-1:0]  divisor;
    logic [2:0]        widx;

    logic              tx_pop, tx_empty, tx_full, tx_busy, tx_line;
    logic [CHAR_W-1:0] tx_head;
    logic              rx_push, rx_empty, rx_full, rx_pop;
    rx_word_t          rx_word, rx_head;
    logic              unused_bits;

    assign widx        = bus_addr[4:2];
    assign divisor     = {div_hi, div_lo};
    assign rx_pop      = bus_rd && (widx == RG_DATA) && !rx_empty;
    assign unused_bits = ^{bus_wdata[31:8], bus_addr[1:0]};

    // register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line    <= '0;
            div_lo  <= '0;
            div_hi  <= '0;
            port_en <= 1'b0;
        end else if (bus_wr) begin
            unique case (widx)
                RG_LINE: line    <= line_cfg_t'(bus_wdata[6:0]);
                RG_DIVM: div_hi  <= bus_wdata[DIVM_W-1:0];
                RG_DIVL: div_lo  <= bus_wdata[DIVL_W-1:0];
                RG_CTRL: port_en <= bus_wdata[0];
                default: ;
            endcase
        end
    end

    // receive status latch and pending overrun
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxstat   <= '0;
            ovr_pend <= 1'b0;
        end else begin
            if (rx_pop) rxstat <= {ovr_pend, rx_head.par_err, rx_head.frm_err};
            if (rx_push && rx_full) ovr_pend <= 1'b1;
            else if (rx_pop)        ovr_pend <= 1'b0;
        end
    end

    // register read mux
    always_comb begin
        bus_rdata = '0;
        unique case (widx)
            RG_DATA: bus_rdata[CHAR_W-1:0] = rx_empty ? '0 : rx_head.data;
            RG_RXST: bus_rdata[2:0]        = rxstat;
            RG_LINE: bus_rdata[6:0]        = line;
            RG_DIVM: bus_rdata[DIVM_W-1:0] = div_hi;
            RG_DIVL: bus_rdata[DIVL_W-1:0] = div_lo;
            RG_CTRL: bus_rdata[0]          = port_en;
            RG_FLAG: bus_rdata[5:3]        = {tx_full, rx_empty, tx_busy};
            default: bus_rdata             = '0;
        endcase
    end

    uart_fifo #(.W(CHAR_W), .DEPTH(Q_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .one_deep(!line.q_en),
        .push(bus_wr && widx == RG_DATA), .wdata(bus_wdata[CHAR_W-1:0]),
        .pop(tx_pop), .head(tx_head), .empty(tx_empty), .full(tx_full)
    );

    uart_fifo #(.W(RXW_W), .DEPTH(Q_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .one_deep(!line.q_en),
        .push(rx_push), .wdata(rx_word),
        .pop(rx_pop), .head(rx_head), .empty(rx_empty), .full(rx_full)
    );

    uart_tx #(.DIV_W(DIV_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .en(port_en), .cfg(line), .div(divisor),
        .q_empty(tx_empty), .q_data(tx_head), .pop(tx_pop),
        .txd_q(tx_line), .busy(tx_busy)
    );

    uart_rx #(.DIV_W(DIV_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(port_en), .cfg(line), .div(divisor),
        .rxd(rxd), .push(rx_push), .word(rx_word)
    );

    assign txd    = tx_line && !line.brk;
    assign irq_rx = !rx_empty;
    assign irq_tx = port_en && !tx_full;

    // R6
    overrun_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full) |=> ovr_pend);

    // R5
    status_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |=> (rxstat[1:0] == $past({rx_head.par_err, rx_head.frm_err})));

    // R9
    send_only_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> port_en);
endmodule

// File: tb/sim_uart_splitdiv.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module sim_uart_splitdiv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        txd, irq_rx, irq_tx;
    logic        loop_en = 1'b0;
    logic        drv_rxd = 1'b1;
    logic        rxd;
    int          total = 0;
    int          bad = 0;

    localparam logic [4:0] A_DATA = 5'h00, A_RXST = 5'h04, A_LINE = 5'h08,
                           A_DIVM = 5'h0C, A_DIVL = 5'h10, A_CTRL = 5'h14,
                           A_FLAG = 5'h18;

    assign rxd = loop_en ? txd : drv_rxd;

    always #2 clk = ~clk;

    uart_splitdiv u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rxd(rxd), .txd(txd), .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic setup(input int dv, input logic [7:0] line);
        wr(A_CTRL, 0);
        wr(A_DIVL, dv & 8'hFF);
        wr(A_DIVM, (dv >> 8) & 4'hF);
        wr(A_LINE, line);
        wr(A_CTRL, 1);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // drive one frame on rxd; pmode 0 none, 1 correct even, 2 wrong even
    task automatic send_frame(input int nb, input logic [7:0] d, input int pmode,
                              input logic stopv, input int bt);
        drv_rxd = 1'b0; idle(bt);
        for (int i = 0; i < nb; i++) begin drv_rxd = d[i]; idle(bt); end
        if (pmode != 0) begin
            drv_rxd = (^(d & 8'((1 << nb) - 1))) ^ (pmode == 2);
            idle(bt);
        end
        drv_rxd = stopv;
        idle(stopv ? bt : (bt * 10) / 16);
        drv_rxd = 1'b1;
    endtask

    // decode nb bits after the start bit of the next frame on txd
    task automatic grab(input int nb, input int bt, output logic [11:0] bits);
        bits = '0;
        while (txd !== 1'b0) @(negedge clk);
        idle(bt / 2);
        for (int i = 0; i < nb; i++) begin idle(bt); bits[i] = txd; end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R12 txd", {31'b0, txd}, 1);
        chk("R12 irq", {30'b0, irq_rx, irq_tx}, 0);
        rd(A_CTRL, v); chk("R12 ctrl", v, 0);
        rd(A_FLAG, v); chk("R12 flags", v, 32'h10);
    endtask

    task automatic t_loop8;
        logic [31:0] v;
        loop_en = 1'b1;
        setup(0, 8'h70);
        chk("R11 irq_tx enabled", {31'b0, irq_tx}, 1);
        wr(A_DATA, 32'hFFFF_FFA5);
        wr(A_DATA, 32'h3C);
        idle(20);
        rd(A_FLAG, v); chk("R10 busy flag", v & 32'h8, 32'h8);
        idle(400);
        chk("R11 irq_rx", {31'b0, irq_rx}, 1);
        rd(A_FLAG, v); chk("R10 rx not empty", v, 0);
        rd(A_DATA, v); chk("R4 first char", v, 32'hA5);
        rd(A_RXST, v); chk("R5 clean status", v, 0);
        rd(A_DATA, v); chk("R4 second char", v, 32'h3C);
        rd(A_FLAG, v); chk("R10 drained", v, 32'h10);
        chk("R11 irq_rx low", {31'b0, irq_rx}, 0);
    endtask

    task automatic t_frames;
        logic [11:0] b;
        logic [31:0] v;
        // 5 bits, even parity, two stops, divisor 1
        loop_en = 1'b0;
        setup(1, 8'h1E);
        wr(A_DATA, 32'h3A);
        grab(8, 32, b);
        chk("R2 5E2 frame", {20'b0, b}, {24'b0, 8'b1111_1010});
        idle(200);
        // 7 bits, odd parity, looped back
        loop_en = 1'b1;
        setup(0, 8'h52);
        wr(A_DATA, 32'h55);
        grab(9, 16, b);
        chk("R2 7O1 frame", {20'b0, b}, {23'b0, 9'b1_1_1010101});
        idle(100);
        rd(A_DATA, v); chk("R4 7-bit char", v, 32'h55);
        rd(A_RXST, v); chk("R5 7O1 status", v, 0);
    endtask

    task automatic t_baud;
        logic [31:0] v;
        int n;
        loop_en = 1'b0;
        setup(12'h101, 8'h70);
        wr(A_DATA, 32'hFF);
        while (txd !== 1'b0) @(negedge clk);
        n = 0;
        while (txd !== 1'b1) begin @(negedge clk); n++; end
        chk("R1 start bit length", n, 16 * 258);
        v = 32'h8;
        while (v[3]) begin idle(200); rd(A_FLAG, v); end
        chk("R10 idle after frame", v, 32'h10);
    endtask

    task automatic t_break;
        logic [31:0] v;
        loop_en = 1'b0;
        setup(0, 8'h71);
        wr(A_DATA, 32'h00);
        idle(5);
        chk("R3 break low", {31'b0, txd}, 0);
        idle(100);
        chk("R3 break held", {31'b0, txd}, 0);
        wr(A_DATA, 32'hFF);
        idle(200);
        chk("R3 break over char", {31'b0, txd}, 0);
        wr(A_LINE, 32'h70);
        idle(400);
        chk("R3 released", {31'b0, txd}, 1);
        rd(A_FLAG, v); chk("R10 after break", v, 32'h10);
    endtask

    task automatic t_errors;
        logic [31:0] v;
        loop_en = 1'b0;
        setup(0, 8'h76);
        send_frame(8, 8'h0F, 2, 1'b1, 16);
        idle(20);
        send_frame(8, 8'h81, 1, 1'b0, 16);
        idle(48);
        send_frame(8, 8'h42, 1, 1'b1, 16);
        idle(40);
        rd(A_DATA, v); chk("R4 char bad parity", v, 32'h0F);
        rd(A_RXST, v); chk("R5 parity bit", v, 32'h2);
        rd(A_DATA, v); chk("R4 char bad stop", v, 32'h81);
        rd(A_RXST, v); chk("R5 framing bit", v, 32'h1);
        rd(A_DATA, v); chk("R4 clean char", v, 32'h42);
        rd(A_RXST, v); chk("R5 cleared", v, 0);
    endtask

    task automatic t_glitch;
        logic [31:0] v;
        loop_en = 1'b0;
        setup(0, 8'h70);
        drv_rxd = 1'b0; idle(4); drv_rxd = 1'b1;
        idle(200);
        rd(A_FLAG, v); chk("R7 glitch rejected", v, 32'h10);
        send_frame(8, 8'h5A, 0, 1'b1, 16);
        idle(20);
        rd(A_DATA, v); chk("R7 recovers", v, 32'h5A);
    endtask

    task automatic t_overrun;
        logic [31:0] v;
        loop_en = 1'b0;
        setup(0, 8'h70);
        for (int i = 0; i < 17; i++) send_frame(8, 8'(8'h10 + i), 0, 1'b1, 16);
        idle(20);
        for (int i = 0; i < 16; i++) begin
            rd(A_DATA, v); chk("R6 kept char", v, 32'(8'h10 + i));
            rd(A_RXST, v); chk("R6 overrun on first read only", v, (i == 0) ? 32'h4 : 32'h0);
        end
        rd(A_FLAG, v); chk("R6 17th dropped", v, 32'h10);
    endtask

    task automatic t_depth;
        logic [31:0] v;
        // single-entry mode
        loop_en = 1'b0;
        setup(0, 8'h60);
        wr(A_CTRL, 0);
        rd(A_CTRL, v); chk("R9 ctrl readback off", v, 0);
        chk("R11 irq_tx while off", {31'b0, irq_tx}, 0);
        wr(A_DATA, 32'h11);
        rd(A_FLAG, v); chk("R8 one-deep full", v, 32'h30);
        wr(A_DATA, 32'h22);
        idle(300);
        chk("R9 silent while off", {31'b0, txd}, 1);
        loop_en = 1'b1;
        wr(A_CTRL, 1);
        rd(A_CTRL, v); chk("R9 ctrl readback on", v, 1);
        idle(400);
        rd(A_DATA, v); chk("R8 one-deep char", v, 32'h11);
        rd(A_FLAG, v); chk("R8 extra write ignored", v, 32'h10);
        // sixteen-entry mode
        loop_en = 1'b0;
        setup(0, 8'h70);
        wr(A_CTRL, 0);
        for (int i = 0; i < 15; i++) wr(A_DATA, 32'(8'h40 + i));
        rd(A_FLAG, v); chk("R8 not full at 15", v & 32'h20, 0);
        wr(A_DATA, 32'h4F);
        rd(A_FLAG, v); chk("R8 full at 16", v & 32'h20, 32'h20);
        wr(A_DATA, 32'hEE);
        loop_en = 1'b1;
        wr(A_CTRL, 1);
        idle(16 * 160 + 300);
        for (int i = 0; i < 16; i++) begin
            rd(A_DATA, v); chk("R8 queued order", v, 32'(8'h40 + i));
        end
        rd(A_FLAG, v); chk("R8 17th write ignored", v, 32'h10);
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog got=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        t_reset;
        t_loop8;
        t_frames;
        t_baud;
        t_break;
        t_errors;
        t_glitch;
        t_overrun;
        t_depth;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule